// File: doc/BRIEF.md
# Post-Idle Receive Blanking Timer

This block sits on the receive symbol path of a serial link controller. An upstream detector flags the arrival of an electrical idle ordered set with a one-cycle pulse. The block then holds off all received data for a programmable minimum time, so that noise on a lane going idle cannot look like an idle-exit sequence. While the hold-off runs, the outgoing symbol stream is squashed: valid is low and data is zero. The enable for the idle-exit detectors (EIEOS, TS1 and FTS recognisers) is also withdrawn.

The hold-off length comes from a 4-bit setting that counts in 16 ns units. The setting resets to 3, which is 48 ns. A free-running prescaler turns the core clock into one tick per 16 ns. The default core clock is 250 MHz, so one tick is 4 cycles. The setting is captured when the hold-off starts. A new idle pulse during a hold-off starts it again from the beginning. A bypass control switches blanking off completely, for test use only.

Top module: `rx_idle_blanker`

## Requirements
- R1: After synchronous active-high reset, blank_active_o is 0, exit_det_en_o is 1 and the input stream passes through unchanged.
- R2: With blank_off_i at 0, an eios_det_i pulse in cycle c makes blank_active_o 1 from cycle c+1. The symbol presented in cycle c itself passes through.
- R3: The prescaler ticks in one cycle out of every TICK_CYCLES (4 by default), free-running from reset. The first tick falls in cycle 3 after reset. With setting N, blanking ends on the (N+1)-th tick after the pulse cycle and is 0 in the cycle that follows that tick. This guarantees at least N full 16 ns units.
- R4: A setting of 0 ends blanking on the first tick after the pulse.
- R5: The setting is captured in the pulse cycle. Changing idle_dly_i while blanking is active does not change when blanking ends.
- R6: A pulse that arrives while blanking is active restarts the interval, using the setting present in that cycle.
- R7: While blank_active_o is 1, rx_valid_o is 0 and rx_data_o is all zeros. Otherwise rx_valid_o and rx_data_o equal the inputs in the same cycle.
- R8: exit_det_en_o is always the inverse of blank_active_o. It rises only in the cycle after a tick or after blank_off_i was high.
- R9: While blank_off_i is 1, pulses start no blanking. Raising blank_off_i during blanking clears it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data_i | input | SYM_W | Received symbol |
| rx_valid_i | input | 1 | Received symbol valid |
| eios_det_i | input | 1 | One-cycle pulse: idle ordered set seen |
| idle_dly_i | input | 4 | Minimum hold-off in 16 ns units |
| blank_off_i | input | 1 | Bypass: 1 disables blanking |
| rx_data_o | output | SYM_W | Symbol after blanking |
| rx_valid_o | output | 1 | Valid after blanking |
| blank_active_o | output | 1 | Hold-off in progress |
| exit_det_en_o | output | 1 | Enable for the idle-exit detectors |

## Verification
The assertions assume that the idle pulse and the bypass are clean synchronous levels sampled at each edge. They also assume that reset is held for at least one edge, so that the prescaler phase is known. They make no assumption about the spacing of pulses. The stimulus drives every input at the falling edge. It places idle pulses at each of the four prescaler phases, back to back during an active hold-off, and together with the bypass, so every ordering the rules allow is covered. Nothing relies on a pulse lasting more than one cycle.

// File: rtl/rx_blank_pkg.sv
package rx_blank_pkg;

    localparam int SYM_W    = 8;
    localparam int DLY_W    = 4;
    localparam int DLY_RST  = 3;

    typedef struct packed {
        logic             valid;
        logic [SYM_W-1:0] data;
    } rx_sym_t;

    typedef enum logic {
        GATE_OPEN  = 1'b0,
        GATE_SHUT  = 1'b1
    } gate_st_e;

    function automatic int ticks_per_unit(input int clk_ps, input int unit_ps);
        return (unit_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic rx_sym_t squash(input rx_sym_t s, input logic shut);
        rx_sym_t r;
        r = s;
        if (shut) begin
            r.valid = 1'b0;
            r.data  = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_blank_prescaler.sv
module rx_blank_prescaler #(
    parameter int TICK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    generate
        if (TICK_CYCLES > 1) begin : g_div
            logic [CW-1:0] phase_q;
            always_ff @(posedge clk) begin
                if (rst)                phase_q <= '0;
                else if (phase_q == LAST) phase_q <= '0;
                else                    phase_q <= phase_q + 1'b1;
            end
            assign tick_o = (phase_q == LAST);

            // R3: a tick never lasts two cycles
            a_r3_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rx_blank_timer.sv
module rx_blank_timer
    import rx_blank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             bypass_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             shut_o
);
    gate_st_e         st_q;
    logic [DLY_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= GATE_OPEN;
            left_q <= '0;
        end else if (bypass_i) begin
            st_q   <= GATE_OPEN;
        end else if (start_i) begin
            st_q   <= GATE_SHUT;
            left_q <= dly_i;
        end else if (st_q == GATE_SHUT && tick_i) begin
            if (left_q == '0) st_q   <= GATE_OPEN;
            else              left_q <= left_q - 1'b1;
        end
    end

    assign shut_o = (st_q == GATE_SHUT);

    // R2: a pulse without bypass shuts the gate on the next cycle
    a_r2_pulse_shuts: assert property (@(posedge clk) disable iff (rst)
        (start_i && !bypass_i) |=> shut_o);

    // R9: bypass always leaves the gate open
    a_r9_bypass_opens: assert property (@(posedge clk) disable iff (rst)
        bypass_i |=> !shut_o);

    // R3: without a tick the hold-off cannot finish
    a_r3_no_early_open: assert property (@(posedge clk) disable iff (rst)
        (shut_o && !tick_i && !bypass_i) |=> shut_o);

    // R5: the remaining count only falls while shut and not restarted
    a_r5_count_monotone: assert property (@(posedge clk) disable iff (rst)
        (shut_o && !start_i && !bypass_i) |=> (left_q <= $past(left_q)));
endmodule

// File: rtl/rx_blank_gate.sv
module rx_blank_gate
    import rx_blank_pkg::*;
(
    input  rx_sym_t in_i,
    input  logic    shut_i,
    output rx_sym_t out_o
);
    always_comb out_o = squash(in_i, shut_i);
endmodule

// File: rtl/rx_idle_blanker.sv
module rx_idle_blanker
    import rx_blank_pkg::*;
#(
    parameter int CLK_PS  = 4000,
    parameter int UNIT_PS = 16000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] rx_data_i,
    input  logic             rx_valid_i,
    input  logic             eios_det_i,
    input  logic [DLY_W-1:0] idle_dly_i,
    input  logic             blank_off_i,
    output logic [SYM_W-1:0] rx_data_o,
    output logic             rx_valid_o,
    output logic             blank_active_o,
    output logic             exit_det_en_o
);
    localparam int TICK_CYCLES = ticks_per_unit(CLK_PS, UNIT_PS);

    logic    tick;
    logic    shut;
    rx_sym_t sym_in;
    rx_sym_t sym_out;

    rx_blank_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    rx_blank_timer u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .start_i  (eios_det_i),
        .bypass_i (blank_off_i),
        .dly_i    (idle_dly_i),
        .shut_o   (shut)
    );

    assign sym_in.valid = rx_valid_i;
    assign sym_in.data  = rx_data_i;

    rx_blank_gate u_gate (
        .in_i   (sym_in),
        .shut_i (shut),
        .out_o  (sym_out)
    );

    assign rx_data_o      = sym_out.data;
    assign rx_valid_o     = sym_out.valid;
    assign blank_active_o = shut;
    assign exit_det_en_o  = !shut;

    // R7: nothing leaks while the hold-off runs
    a_r7_squashed: assert property (@(posedge clk) disable iff (rst)
        blank_active_o |-> (!rx_valid_o && rx_data_o == '0));

    // R8: the exit detectors come back only after a tick or bypass
    a_r8_reopen_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(exit_det_en_o) |-> ($past(tick) || $past(blank_off_i)));
endmodule

// File: tb/rx_idle_blanker_test.sv
module rx_idle_blanker_test;
    localparam int TPU = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_data_i = '0;
    logic       rx_valid_i = 1'b0;
    logic       eios_det_i = 1'b0;
    logic [3:0] idle_dly_i = 4'd3;
    logic       blank_off_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_valid_o;
    logic       blank_active_o;
    logic       exit_det_en_o;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int blank_end = -1;
    string req = "R1";

    rx_idle_blanker uut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string r, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", r, what, k, act, exp);
        end
    endtask

    function automatic int end_cycle(input int c, input int n);
        int t1 = c + 1;
        while ((t1 % TPU) != TPU - 1) t1++;
        return t1 + TPU * n;
    endfunction

    task automatic compare_all();
        bit eb = (k <= blank_end);
        check(req, blank_active_o, eb, "blank_active");
        check("R8", exit_det_en_o, !eb, "exit_en");
        check("R7", rx_valid_o, eb ? 0 : rx_valid_i, "valid");
        check("R7", rx_data_o, eb ? 0 : rx_data_i, "data");
    endtask

    task automatic step(input bit e, input int dly, input bit dis);
        @(negedge clk);
        k++;
        rx_data_i   = 8'($urandom);
        rx_valid_i  = 1'($urandom);
        eios_det_i  = e;
        idle_dly_i  = 4'(dly);
        blank_off_i = dis;
        #1;
        compare_all();
        if (dis)    blank_end = -1;
        else if (e) blank_end = end_cycle(k, dly);
    endtask

    task automatic idle(input int n, input int dly);
        for (int i = 0; i < n; i++) step(0, dly, 0);
    endtask

    task automatic to_phase(input int p);
        while (((k + 1) % TPU) != p) step(0, 3, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0;
        rx_data_i = 8'hA5; rx_valid_i = 1'b1;
        #1;
        req = "R1";
        check("R1", blank_active_o, 0, "reset blank");
        check("R1", exit_det_en_o, 1, "reset exit_en");
        check("R1", rx_data_o, 8'hA5, "reset data");
        req = "R7"; idle(6, 3);

        req = "R3";
        for (int p = 0; p < TPU; p++) begin
            to_phase(p);
            step(1, 3, 0);
            idle(2, 3);
            check("R2", blank_active_o, 1, "blank after pulse");
            idle(20, 3);
        end
        req = "R4";
        for (int p = 0; p < TPU; p++) begin
            to_phase(p); step(1, 0, 0); idle(8, 0);
        end
        req = "R3";
        step(1, 15, 0); idle(70, 15);

        req = "R5";
        step(1, 2, 0);
        for (int i = 0; i < 16; i++) step(0, 15 - i, 0);
        check("R5", blank_active_o, 0, "ignored setting change");

        req = "R6";
        step(1, 3, 0); idle(5, 3); step(1, 6, 0); idle(14, 3);
        check("R6", blank_active_o, 1, "restart extends");
        idle(20, 3);
        step(1, 1, 0); step(1, 0, 0); idle(10, 0);

        req = "R9";
        step(1, 5, 1); idle(1, 5);
        check("R9", blank_active_o, 0, "pulse with bypass");
        step(1, 8, 0); idle(3, 8); step(0, 8, 1);
        check("R9", blank_active_o, 1, "bypass same cycle");
        idle(1, 8);
        check("R9", blank_active_o, 0, "bypass clears");
        step(1, 4, 1); step(1, 4, 1); idle(10, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule